// File: doc/BRIEF.md
# Configurable Matrix Tile Register File

This block holds eight two-dimensional tile registers of 1024 bytes each, organised as up to 16 rows of 64 bytes. A 64-byte configuration word, written in one cycle, gives each tile a live shape: a row count and a row length in bytes. That shape bounds every tile operation. Bytes past the row length and rows past the row count are never fetched or written to memory, and they read back as zero after a load or a clear.

Four operations act on one tile at a time: clear, load from a request/response memory port with a byte stride between rows, store to that port with the same addressing, and release, which returns the configuration to the unconfigured state. A load or store moves one memory beat per configured row, in row order. An operation issued against an unconfigured or malformed configuration raises an error pulse and touches neither the tiles nor memory. An external compute engine reads any tile row combinationally through a separate read port.

Top module: `tile_file`

## Requirements
- R1: After reset every tile reads as all zero and the configuration is unconfigured, so clear, load and store each raise `err` and not `done`.
- R2: The configuration word is little-endian by byte. Byte 0 is the palette and must be 1. Byte 1 is the start row and must be 0. Tile t takes its row length from bytes 16+2t and 17+2t, as a 16-bit little-endian value, and its row count from byte 48+t. Shape entries 8 to 15 have no effect on any tile.
- R3: An operation other than release raises `err` for one cycle, the cycle after it is accepted, when the target tile is illegal. The tile is illegal when the block is unconfigured, the palette is not 1, the start row is not 0, the row count is above 16, or the row length is above 64. No tile changes and no memory beat occurs.
- R4: Clear (op code 0) sets all 1024 bytes of the tile to zero and pulses `done`.
- R5: Load (op code 1) fetches row r from address base + r*stride, one beat per row. Within each row, bytes below the row length take their value from memory and the other bytes become zero. Rows at or above the row count become zero, and the other tiles do not change.
- R6: Store (op code 2) drives one write beat per configured row, holding row r at address base + r*stride. The byte enable has exactly its low row-length bits set, so memory bytes outside the enabled range keep their values.
- R7: Release (op code 3) pulses `done` and returns the block to the unconfigured state, so the next clear, load or store raises `err`.
- R8: `done` pulses one cycle after the final accepted beat. A load or store with a row count of 0 makes no memory beat and pulses `done` in the cycle after it is accepted.
- R9: While a load or store is in progress, `busy` is high and new operations and configuration writes are ignored.
- R10: A memory request holds its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write the configuration word |
| cfg_data | input | 512 | Configuration word, byte 0 in bits 7:0 |
| op_valid | input | 1 | Issue an operation |
| op_code | input | 2 | 0 clear, 1 load, 2 store, 3 release |
| op_tile | input | 3 | Target tile |
| op_base | input | 32 | Byte address of row 0 |
| op_stride | input | 32 | Byte distance between rows |
| busy | output | 1 | Load or store in progress |
| done | output | 1 | Operation finished (one-cycle pulse) |
| err | output | 1 | Operation refused (one-cycle pulse) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 512 | Write row data |
| mem_be | output | 64 | Write byte enables |
| mem_ack | input | 1 | Request accepted, read data valid |
| mem_rdata | input | 512 | Read row data |
| rd_tile | input | 3 | Read port tile select |
| rd_row | input | 4 | Read port row select |
| rd_data | output | 512 | Read port row data |

## Verification
The bench builds the block with its defaults: eight tiles of 16 rows by 64 bytes, and 32-bit addresses. With these values it can reach the full-shape edges (16 rows, 64-byte rows) and the values just past them (17, 65). It can also reach strides shorter than a row, so that store beats overlap, and random acknowledge delays that hold requests open. A 4 KB bench memory with wrapped addresses covers every base and stride the random stimulus draws.

// File: rtl/tile_file.sv
module tile_file #(
  parameter int NT = 8,
  parameter int ROWS = 16,
  parameter int RB = 64,
  parameter int AW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [511:0]          cfg_data,
  input  logic                  op_valid,
  input  logic [1:0]            op_code,
  input  logic [$clog2(NT)-1:0] op_tile,
  input  logic [AW-1:0]         op_base,
  input  logic [AW-1:0]         op_stride,
  output logic                  busy,
  output logic                  done,
  output logic                  err,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [RB*8-1:0]       mem_wdata,
  output logic [RB-1:0]         mem_be,
  input  logic                  mem_ack,
  input  logic [RB*8-1:0]       mem_rdata,
  input  logic [$clog2(NT)-1:0] rd_tile,
  input  logic [$clog2(ROWS)-1:0] rd_row,
  output logic [RB*8-1:0]       rd_data
);
  localparam int DW = RB * 8;
  localparam int TW = $clog2(NT);
  localparam int RW = $clog2(ROWS);
  localparam int NE = NT * ROWS;

  logic [DW-1:0] tdat [NE];
  logic          cfg_on;
  logic [7:0]    pal, srow;
  logic [15:0]   colsb [NT];
  logic [7:0]    nrow [NT];

  logic          cur_ld;
  logic [TW-1:0] cur_tile;
  logic [AW-1:0] base, stride;
  logic [7:0]    row;
  logic [TW+RW-1:0] idx;

  function automatic logic [RB-1:0] len_mask(input logic [15:0] c);
    for (int i = 0; i < RB; i++) len_mask[i] = (i < int'(c));
  endfunction

  function automatic logic [DW-1:0] widen(input logic [RB-1:0] m);
    for (int i = 0; i < RB; i++) widen[i*8 +: 8] = {8{m[i]}};
  endfunction

  wire legal = cfg_on && pal == 8'd1 && srow == 8'd0 &&
               int'(nrow[op_tile]) <= ROWS && int'(colsb[op_tile]) <= RB;
  wire [RB-1:0] bmask = len_mask(colsb[cur_tile]);
  wire last = row == nrow[cur_tile] - 8'd1;

  assign idx       = {cur_tile, row[RW-1:0]};
  assign mem_req   = busy;
  assign mem_we    = busy && !cur_ld;
  assign mem_addr  = base + AW'(row) * stride;
  assign mem_wdata = tdat[idx];
  assign mem_be    = mem_we ? bmask : '0;
  assign rd_data   = tdat[{rd_tile, rd_row}];

  always_ff @(posedge clk) begin
    done <= 1'b0;
    err  <= 1'b0;
    if (!rst_n) begin
      busy <= 1'b0;
      cfg_on <= 1'b0;
      pal <= '0;
      srow <= '0;
      cur_ld <= 1'b0;
      cur_tile <= '0;
      base <= '0;
      stride <= '0;
      row <= '0;
      for (int t = 0; t < NT; t++) begin
        colsb[t] <= '0;
        nrow[t] <= '0;
      end
      for (int e = 0; e < NE; e++) tdat[e] <= '0;
    end else if (busy) begin
      if (mem_ack) begin
        if (cur_ld) tdat[idx] <= mem_rdata & widen(bmask);
        row <= row + 8'd1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end else if (cfg_we) begin
      cfg_on <= 1'b1;
      pal <= cfg_data[7:0];
      srow <= cfg_data[15:8];
      for (int t = 0; t < NT; t++) begin
        colsb[t] <= cfg_data[(16 + 2*t)*8 +: 16];
        nrow[t]  <= cfg_data[(48 + t)*8 +: 8];
      end
    end else if (op_valid) begin
      if (op_code == 2'd3) begin
        cfg_on <= 1'b0;
        pal <= '0;
        srow <= '0;
        for (int t = 0; t < NT; t++) begin
          colsb[t] <= '0;
          nrow[t] <= '0;
        end
        done <= 1'b1;
      end else if (!legal) begin
        err <= 1'b1;
      end else begin
        if (op_code != 2'd2)
          for (int r = 0; r < ROWS; r++) tdat[{op_tile, RW'(r)}] <= '0;
        cur_tile <= op_tile;
        cur_ld <= op_code == 2'd1;
        base <= op_base;
        stride <= op_stride;
        row <= '0;
        if (op_code == 2'd0 || nrow[op_tile] == 8'd0) done <= 1'b1;
        else busy <= 1'b1;
      end
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_req && !done);
  // R6
  be_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> ((mem_be & (mem_be + RB'(1))) == '0));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req && !busy);
  // R9
  busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_we |=> $stable(cfg_on));
endmodule

// File: tb/test_tile_file.sv
module test_tile_file;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [511:0] cfg_data = '0;
  logic op_valid = 1'b0;
  logic [1:0] op_code = '0;
  logic [2:0] op_tile = '0;
  logic [31:0] op_base = '0, op_stride = '0;
  logic busy, done, err, mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [511:0] mem_wdata, mem_rdata = '0, rd_data;
  logic [63:0] mem_be;
  logic mem_ack = 1'b0;
  logic [2:0] rd_tile = '0;
  logic [3:0] rd_row = '0;

  tile_file i_tile_file (.*);

  always #2.5 clk = ~clk;

  logic [7:0] mem [4096];
  logic [7:0] emem [4096];
  logic [511:0] mt [128];
  bit m_on;
  int m_pal, m_srow, m_cb [16], m_rw [16];
  int beats = 0, checks = 0, fails = 0;

  task automatic chk(string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (mem_req && $urandom_range(0, 2) != 0) begin
      mem_ack = 1'b1;
      beats++;
      for (int b = 0; b < 64; b++) begin
        if (mem_we) begin
          if (mem_be[b]) mem[(mem_addr + b) & 4095] = mem_wdata[b*8 +: 8];
        end else mem_rdata[b*8 +: 8] = mem[(mem_addr + b) & 4095];
      end
    end
  end

  task automatic set_cfg(int pal, int srow);
    @(negedge clk);
    cfg_data = '0;
    cfg_data[7:0] = 8'(pal);
    cfg_data[15:8] = 8'(srow);
    for (int i = 0; i < 16; i++) begin
      cfg_data[(16 + 2*i)*8 +: 16] = 16'(m_cb[i]);
      cfg_data[(48 + i)*8 +: 8] = 8'(m_rw[i]);
    end
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_on = 1; m_pal = pal; m_srow = srow;
  endtask

  task automatic check_tile(int t, string req);
    for (int r = 0; r < 16; r++) begin
      rd_tile = 3'(t); rd_row = 4'(r);
      #0.1 chk(req, rd_data, mt[t*16 + r]);
    end
  endtask

  task automatic check_mem(string req);
    logic [511:0] bad = '0;
    for (int a = 0; a < 4096; a++) if (mem[a] !== emem[a]) bad = 512'(a + 1);
    chk(req, bad, '0);
  endtask

  task automatic exec(int code, int t, int base, int stride, string req);
    bit legal, gd, ge;
    int b0, exp_beats;
    legal = code == 3 || (m_on && m_pal == 1 && m_srow == 0 && m_rw[t] <= 16 && m_cb[t] <= 64);
    b0 = beats;
    @(negedge clk);
    op_valid = 1'b1; op_code = 2'(code); op_tile = 3'(t);
    op_base = 32'(base); op_stride = 32'(stride);
    @(negedge clk);
    op_valid = 1'b0;
    gd = 0; ge = 0;
    for (int k = 0; k < 400 && !gd && !ge; k++) begin
      gd = done; ge = err;
      if (!gd && !ge) @(negedge clk);
    end
    chk({req, " err"}, 512'(ge), 512'(!legal));
    chk({req, " done"}, 512'(gd), 512'(legal));
    exp_beats = 0;
    if (legal) begin
      if (code == 3) begin
        m_on = 0; m_pal = 0; m_srow = 0;
        for (int i = 0; i < 16; i++) begin m_cb[i] = 0; m_rw[i] = 0; end
      end else if (code == 2) begin
        exp_beats = m_rw[t];
        for (int r = 0; r < m_rw[t]; r++)
          for (int b = 0; b < m_cb[t]; b++)
            emem[(base + r*stride + b) & 4095] = mt[t*16 + r][b*8 +: 8];
      end else begin
        for (int r = 0; r < 16; r++) mt[t*16 + r] = '0;
        if (code == 1) begin
          exp_beats = m_rw[t];
          for (int r = 0; r < m_rw[t]; r++)
            for (int b = 0; b < m_cb[t]; b++)
              mt[t*16 + r][b*8 +: 8] = emem[(base + r*stride + b) & 4095];
        end
      end
    end
    chk({req, " beats"}, 512'(beats - b0), 512'(exp_beats));
    check_tile(t, {req, " tile"});
    check_mem({req, " mem"});
  endtask

  task automatic full_shape();
    for (int i = 0; i < 16; i++) begin m_cb[i] = 64; m_rw[i] = 16; end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int a = 0; a < 4096; a++) begin mem[a] = 8'($urandom); emem[a] = mem[a]; end
    for (int e = 0; e < 128; e++) mt[e] = '0;
    m_on = 0; m_pal = 0; m_srow = 0;
    for (int i = 0; i < 16; i++) begin m_cb[i] = 0; m_rw[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and refused operations
    chk("R1 busy", 512'(busy), '0);
    check_tile(0, "R1 reset tile");
    exec(0, 0, 0, 0, "R1 clear unconfigured");
    exec(1, 2, 0, 64, "R1 load unconfigured");
    // R2/R5: full shape load, others untouched
    full_shape();
    set_cfg(1, 0);
    exec(1, 1, 100, 64, "R5 full load");
    exec(1, 3, 7, 70, "R5 full load t3");
    check_tile(1, "R5 other tile kept");
    // R5: partial shape reloads tile 1 with zero padding
    m_cb[1] = 5; m_rw[1] = 3;
    set_cfg(1, 0);
    exec(1, 1, 900, 40, "R5 partial load");
    // R6: store with short rows, overlapping stride
    m_cb[3] = 33; m_rw[3] = 4;
    set_cfg(1, 0);
    exec(2, 3, 2000, 20, "R6 overlap store");
    exec(2, 1, 3000, 64, "R6 partial store");
    // R4
    exec(0, 3, 0, 0, "R4 clear");
    // R8: zero row count
    m_rw[2] = 0; m_cb[2] = 64;
    set_cfg(1, 0);
    exec(1, 2, 50, 64, "R8 empty load");
    exec(2, 2, 50, 64, "R8 empty store");
    // R2: entries 8..15 hold garbage, tiles 0..7 unaffected
    full_shape();
    for (int i = 8; i < 16; i++) begin m_rw[i] = 200; m_cb[i] = 999; end
    set_cfg(1, 0);
    exec(1, 7, 1234, 64, "R2 high entries ignored");
    // R3: each illegal field
    set_cfg(2, 0);
    exec(1, 7, 0, 64, "R3 bad palette");
    set_cfg(1, 1);
    exec(0, 7, 0, 64, "R3 bad start row");
    full_shape(); m_rw[7] = 17;
    set_cfg(1, 0);
    exec(1, 7, 0, 64, "R3 rows 17");
    full_shape(); m_cb[7] = 65;
    set_cfg(1, 0);
    exec(2, 7, 0, 64, "R3 length 65");
    // R9: op and config during a load are dropped
    full_shape();
    set_cfg(1, 0);
    exec(1, 5, 500, 64, "R9 prep");
    begin
      int b0;
      b0 = beats;
      @(negedge clk);
      op_valid = 1'b1; op_code = 2'd1; op_tile = 3'd6; op_base = 32'd10; op_stride = 32'd64;
      @(negedge clk);
      op_code = 2'd0; op_tile = 3'd5; cfg_we = 1'b1; cfg_data = '0;
      chk("R9 busy", 512'(busy), 512'(1));
      @(negedge clk);
      op_valid = 1'b0; cfg_we = 1'b0;
      for (int k = 0; k < 400 && !done; k++) @(negedge clk);
      for (int r = 0; r < 16; r++)
        for (int b = 0; b < 64; b++) mt[96 + r][b*8 +: 8] = emem[(10 + r*64 + b) & 4095];
      chk("R9 beats", 512'(beats - b0), 512'(16));
      check_tile(5, "R9 tile 5 kept");
      check_tile(6, "R9 tile 6 loaded");
      exec(1, 4, 0, 64, "R9 config kept");
    end
    // R7
    exec(3, 0, 0, 0, "R7 release");
    exec(2, 4, 0, 64, "R7 store after release");
    // random mix (R4 R5 R6 R10)
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 16; i++) begin
        m_cb[i] = $urandom_range(0, 66); m_rw[i] = $urandom_range(0, 17);
      end
      set_cfg(1, 0);
      exec($urandom_range(0, 2), $urandom_range(0, 7), $urandom_range(0, 2047),
           $urandom_range(0, 127), "R10 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule